// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic, Logic and Bit-Manipulation Unit

This block is a purely combinational 16-bit execution unit. It takes two operands, X and Y, and an operation code. It returns one result and four status flags: zero, negative, carry and overflow. Dedicated sections perform add/subtract, bitwise logic, single-step shifts and single-bit manipulation. A final multiplexer chooses which section drives the result. Negation reuses the subtractor with a zero minuend. Complement reuses the XOR path with an all-ones operand.

Either operand can be replaced by a small constant before it reaches the sections. The available constants are zero, plus one, minus one, plus two and minus two. This lets one operation code cover increments, decrements and clears. For the bit operations, a one-hot decoder builds the mask from the low four bits of the effective Y operand. A separate tap reads the targeted bit of X before it is modified, and the zero flag for bit operations comes from that tap.

Top module: `alu16_core`

## Requirements
- R1: Operation code 0 (add) gives result = X + Y modulo 2^16. C is the carry out of bit 15. V is set on signed two's-complement overflow.
- R2: Operation code 1 (subtract) gives result = X - Y modulo 2^16. C is set when a borrow occurs, that is when X < Y unsigned. V is set on signed overflow.
- R3: Operation code 8 (negate) gives result = 0 - X. C is set when X is non-zero. V is set only when X = 0x8000.
- R4: Operation codes 2, 3 and 4 give X AND Y, X OR Y and X XOR Y respectively. C and V are 0 for all three.
- R5: Operation code 9 (complement) gives X XOR 0xFFFF. C and V are 0.
- R6: Operation code 5 shifts X left by one bit and fills bit 0 with 0. C takes the old X[15]. V is 0.
- R7: Operation code 6 shifts X right by one bit and fills bit 15 with 0. Operation code 7 does the same but copies X[15] into bit 15. For both, C takes the old X[0] and V is 0.
- R8: Operation code 10 (bit test) gives result = X. Z is set when bit X[Y[3:0]] is 0. C and V are 0.
- R9: Operation codes 11, 12 and 13 clear, set and invert bit Y[3:0] of X respectively, and leave every other bit unchanged. Z is set when that bit was 0 before the operation. C and V are 0.
- R10: Each operand has its own 3-bit constant select. The codes are: 0 = the port value, 1 = 0x0000, 2 = 0x0001, 3 = 0xFFFF, 4 = 0x0002, 5 = 0xFFFE, and 6 or 7 = the port value. The substituted value is used by every section, including the bit index taken from Y.
- R11: For operation codes 0 to 9, Z is set exactly when the result is zero. For operation codes 0 to 13, N equals result bit 15.
- R12: Operation codes 14 and 15 are reserved. They give result 0 with all four flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 16 | X operand from the port |
| y_i | input | 16 | Y operand from the port; its low 4 bits are the bit index |
| x_sel_i | input | 3 | Constant select for X |
| y_sel_i | input | 3 | Constant select for Y |
| op_i | input | 4 | Operation code |
| result_o | output | 16 | Selected result |
| flag_z_o | output | 1 | Zero flag, or targeted bit clear for bit operations |
| flag_n_o | output | 1 | Result bit 15 |
| flag_c_o | output | 1 | Carry, borrow or shifted-out bit |
| flag_v_o | output | 1 | Signed overflow |

## Verification
In a bit clear, set or change, the logic unit writes the masked value at the same time as the bit tap reads the same bit for the flag. A fault that let the tap see the modified value would invert Z only on these operations. The bench runs every bit index against operands whose targeted bit is both 0 and 1, and expects Z to follow the value the bit had beforehand. Constant injection also lands in the same cycle as the bit decoder whenever Y is replaced. Vectors that pick Y constants with bit operations check that the index comes from the substituted value.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_AND  = 4'd2,  OP_OR   = 4'd3,
    OP_XOR  = 4'd4,  OP_SHL  = 4'd5,  OP_SHR  = 4'd6,  OP_SAR  = 4'd7,
    OP_NEG  = 4'd8,  OP_NOT  = 4'd9,  OP_BTST = 4'd10, OP_BCLR = 4'd11,
    OP_BSET = 4'd12, OP_BCHG = 4'd13, OP_RS14 = 4'd14, OP_RS15 = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    CS_PORT = 3'd0, CS_ZERO = 3'd1, CS_P1 = 3'd2, CS_M1 = 3'd3,
    CS_P2   = 3'd4, CS_M2   = 3'd5, CS_RS6 = 3'd6, CS_RS7 = 3'd7
  } csel_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_PASS} lgc_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu16_opnd.sv
module alu16_opnd
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] port_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] opnd_o
);
  always_comb begin
    unique case (csel_e'(sel_i))
      CS_ZERO: opnd_o = '0;
      CS_P1:   opnd_o = W'(1);
      CS_M1:   opnd_o = '1;
      CS_P2:   opnd_o = W'(2);
      CS_M2:   opnd_o = {{(W-1){1'b1}}, 1'b0};
      default: opnd_o = port_i;
    endcase
  end
endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] b_x;
  logic [W:0]   full;

  assign b_x   = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
  assign sum_o = full[W-1:0];
  // carry out on add, borrow (inverted carry) on subtract
  assign c_o   = full[W] ^ sub_i;
  assign v_o   = (a_i[W-1] == b_x[W-1]) && (full[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  lgc_e         op_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         left_i,
  input  logic         arith_i,
  output logic [W-1:0] y_o,
  output logic         c_o
);
  logic [W-1:0] shl;
  logic [W-1:0] shr;

  assign shl = {a_i[W-2:0], 1'b0};
  assign shr = {arith_i & a_i[W-1], a_i[W-1:1]};
  assign y_o = left_i ? shl : shr;
  assign c_o = left_i ? a_i[W-1] : a_i[0];
endmodule

// File: rtl/alu16_bitsel.sv
module alu16_bitsel #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  mask_o,
  output logic          bit_o
);
  for (genvar g = 0; g < W; g++) begin : g_dec
    assign mask_o[g] = (idx_i == IW'(g));
  end

  // tap of the targeted bit before any modification
  assign bit_o = |(a_i & mask_o);
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [2:0]   x_sel_i,
  input  logic [2:0]   y_sel_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         flag_z_o,
  output logic         flag_n_o,
  output logic         flag_c_o,
  output logic         flag_v_o
);
  localparam int IW = $clog2(W);
  localparam int NO = 2;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [NO-1:0][W-1:0] raw;
  logic [NO-1:0][2:0]   sel;
  logic [NO-1:0][W-1:0] eff;
  logic [W-1:0] x_eff;
  logic [W-1:0] y_eff;

  assign raw = {y_i, x_i};
  assign sel = {y_sel_i, x_sel_i};

  for (genvar g = 0; g < NO; g++) begin : g_opnd
    alu16_opnd #(.W(W)) u_opnd (
      .port_i(raw[g]),
      .sel_i (sel[g]),
      .opnd_o(eff[g])
    );
  end

  assign x_eff = eff[0];
  assign y_eff = eff[1];

  // bit mask and pre-operation bit tap
  logic [W-1:0] mask;
  logic         prior_bit;

  alu16_bitsel #(.W(W), .IW(IW)) u_bitsel (
    .a_i   (x_eff),
    .idx_i (y_eff[IW-1:0]),
    .mask_o(mask),
    .bit_o (prior_bit)
  );

  // operand steering
  logic [W-1:0] add_a, add_b, lgc_b;
  logic         add_sub, sh_left, sh_arith;
  lgc_e         lgc_op;

  always_comb begin
    add_a    = x_eff;
    add_b    = y_eff;
    add_sub  = 1'b0;
    lgc_b    = y_eff;
    lgc_op   = LG_PASS;
    sh_left  = (op == OP_SHL);
    sh_arith = (op == OP_SAR);
    unique case (op)
      OP_SUB:  add_sub = 1'b1;
      OP_NEG: begin
        add_a   = '0;
        add_b   = x_eff;
        add_sub = 1'b1;
      end
      OP_AND:  lgc_op = LG_AND;
      OP_OR:   lgc_op = LG_OR;
      OP_XOR:  lgc_op = LG_XOR;
      OP_NOT: begin
        lgc_b  = '1;
        lgc_op = LG_XOR;
      end
      OP_BCLR: begin
        lgc_b  = ~mask;
        lgc_op = LG_AND;
      end
      OP_BSET: begin
        lgc_b  = mask;
        lgc_op = LG_OR;
      end
      OP_BCHG: begin
        lgc_b  = mask;
        lgc_op = LG_XOR;
      end
      default: ;
    endcase
  end

  logic [W-1:0] add_y, lgc_y, sh_y;
  logic         add_c, add_v, sh_c;

  alu16_addsub #(.W(W)) u_addsub (
    .a_i  (add_a),
    .b_i  (add_b),
    .sub_i(add_sub),
    .sum_o(add_y),
    .c_o  (add_c),
    .v_o  (add_v)
  );

  alu16_logic #(.W(W)) u_logic (
    .a_i (x_eff),
    .b_i (lgc_b),
    .op_i(lgc_op),
    .y_o (lgc_y)
  );

  alu16_shift #(.W(W)) u_shift (
    .a_i    (x_eff),
    .left_i (sh_left),
    .arith_i(sh_arith),
    .y_o    (sh_y),
    .c_o    (sh_c)
  );

  // result multiplexer and flags
  logic [W-1:0] res;
  flags_t       flg;
  logic         is_bit, is_rsv;

  always_comb begin
    res    = '0;
    flg    = '0;
    is_bit = 1'b0;
    is_rsv = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB, OP_NEG: begin
        res   = add_y;
        flg.c = add_c;
        flg.v = add_v;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT: res = lgc_y;
      OP_SHL, OP_SHR, OP_SAR: begin
        res   = sh_y;
        flg.c = sh_c;
      end
      OP_BTST: begin
        res    = x_eff;
        is_bit = 1'b1;
      end
      OP_BCLR, OP_BSET, OP_BCHG: begin
        res    = lgc_y;
        is_bit = 1'b1;
      end
      default: is_rsv = 1'b1;
    endcase
    if (!is_rsv) begin
      flg.z = is_bit ? ~prior_bit : (res == '0);
      flg.n = res[W-1];
    end
  end

  assign result_o = res;
  assign flag_z_o = flg.z;
  assign flag_n_o = flg.n;
  assign flag_c_o = flg.c;
  assign flag_v_o = flg.v;
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic [2:0]   x_sel_i,
  input logic [2:0]   y_sel_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         flag_z_o,
  input logic         flag_n_o,
  input logic         flag_c_o,
  input logic         flag_v_o
);
  localparam int IW = $clog2(W);

  logic          ports;
  logic [IW-1:0] idx;
  logic [W-1:0]  keep;

  assign ports = (x_sel_i == 3'd0) && (y_sel_i == 3'd0);
  assign idx   = y_i[IW-1:0];
  assign keep  = ~(W'(1) << idx);

  always_comb begin
    if (ports && op_i == 4'd0)
      a_r1_add_sum: assert (result_o == W'(x_i + y_i))
        else $error("add sum mismatch");
    if (op_i >= 4'd2 && op_i <= 4'd4 || op_i == 4'd9)
      a_r4_logic_no_cv: assert (!flag_c_o && !flag_v_o)
        else $error("logic op raised C or V");
    if (ports && op_i == 4'd10)
      a_r8_btst_keeps: assert (result_o == x_i && flag_z_o == !x_i[idx])
        else $error("bit test wrong");
    if (ports && op_i >= 4'd11 && op_i <= 4'd13)
      a_r9_bit_only_target: assert (((result_o ^ x_i) & keep) == '0 && flag_z_o == !x_i[idx])
        else $error("bit op touched other bits or wrong Z");
    if (ports && op_i == 4'd11)
      a_r9_bclr_zero: assert (!result_o[idx]) else $error("bclr left bit set");
    if (ports && op_i == 4'd12)
      a_r9_bset_one: assert (result_o[idx]) else $error("bset left bit clear");
    if (x_sel_i == 3'd1 && y_sel_i == 3'd1 && op_i == 4'd0)
      a_r10_zero_consts: assert (result_o == '0 && flag_z_o)
        else $error("zero constants not applied");
    if (op_i <= 4'd13)
      a_r11_n_msb: assert (flag_n_o == result_o[W-1]) else $error("N not msb");
    if (op_i >= 4'd14)
      a_r12_rsv_quiet: assert (result_o == '0 && !flag_z_o && !flag_n_o && !flag_c_o && !flag_v_o)
        else $error("reserved op not quiet");
  end
endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
  .x_i     (x_i),
  .y_i     (y_i),
  .x_sel_i (x_sel_i),
  .y_sel_i (y_sel_i),
  .op_i    (op_i),
  .result_o(result_o),
  .flag_z_o(flag_z_o),
  .flag_n_o(flag_n_o),
  .flag_c_o(flag_c_o),
  .flag_v_o(flag_v_o)
);

// File: tb/alu16_core_bench.sv
module alu16_core_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] x, y, res;
  logic [2:0]  xs, ys;
  logic [3:0]  op;
  logic        fz, fn, fc, fv;
  int          n_vec = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  alu16_core u_alu16_core (
    .x_i(x), .y_i(y), .x_sel_i(xs), .y_sel_i(ys), .op_i(op),
    .result_o(res), .flag_z_o(fz), .flag_n_o(fn), .flag_c_o(fc), .flag_v_o(fv)
  );

  function automatic logic [15:0] cval(input logic [15:0] p, input logic [2:0] s);
    case (s)
      3'd1: return 16'h0000;
      3'd2: return 16'h0001;
      3'd3: return 16'hFFFF;
      3'd4: return 16'h0002;
      3'd5: return 16'hFFFE;
      default: return p;
    endcase
  endfunction

  // returns {result, z, n, c, v}
  function automatic logic [19:0] ref_f(input logic [15:0] xp, yp,
                                        input logic [2:0] xsl, ysl, input logic [3:0] o);
    logic [15:0] a, b, r;
    logic [16:0] t;
    logic z, c, v, bitop, pb;
    a = cval(xp, xsl);
    b = cval(yp, ysl);
    r = 16'h0; c = 1'b0; v = 1'b0; bitop = 1'b0;
    pb = a[b[3:0]];
    case (o)
      4'd0: begin t = {1'b0, a} + {1'b0, b}; r = t[15:0]; c = t[16];
                  v = (a[15] == b[15]) && (r[15] != a[15]); end
      4'd1: begin r = a - b; c = (a < b); v = (a[15] != b[15]) && (r[15] != a[15]); end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: begin r = {a[14:0], 1'b0}; c = a[15]; end
      4'd6: begin r = {1'b0, a[15:1]}; c = a[0]; end
      4'd7: begin r = {a[15], a[15:1]}; c = a[0]; end
      4'd8: begin r = 16'h0 - a; c = (a != 0); v = (a == 16'h8000); end
      4'd9: r = ~a;
      4'd10: begin r = a; bitop = 1'b1; end
      4'd11: begin r = a; r[b[3:0]] = 1'b0; bitop = 1'b1; end
      4'd12: begin r = a; r[b[3:0]] = 1'b1; bitop = 1'b1; end
      4'd13: begin r = a; r[b[3:0]] = ~a[b[3:0]]; bitop = 1'b1; end
      default: return 20'h0;
    endcase
    z = bitop ? ~pb : (r == 0);
    return {r, z, r[15], c, v};
  endfunction

  task automatic apply(input logic [15:0] xv, yv, input logic [2:0] xsv, ysv,
                       input logic [3:0] ov, input string req);
    logic [19:0] exp_v, got;
    @(negedge clk);
    x = xv; y = yv; xs = xsv; ys = ysv; op = ov;
    #1;
    exp_v = ref_f(xv, yv, xsv, ysv, ov);
    got   = {res, fz, fn, fc, fv};
    n_vec++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d x=%h y=%h xs=%0d ys=%0d got res=%h znvc=%b exp res=%h znvc=%b",
               req, ov, xv, yv, xsv, ysv, got[19:4], got[3:0], exp_v[19:4], exp_v[3:0]);
    end
  endtask

  task automatic t_idle();  // R11: all-zero inputs give add of zeros
    apply(16'h0, 16'h0, 3'd0, 3'd0, 4'd0, "R11 idle");
  endtask

  task automatic t_add();
    apply(16'h1234, 16'h4321, 0, 0, 4'd0, "R1 add");
    apply(16'hFFFF, 16'h0001, 0, 0, 4'd0, "R1 carry");
    apply(16'h7FFF, 16'h0001, 0, 0, 4'd0, "R1 overflow");
    apply(16'h8000, 16'h8000, 0, 0, 4'd0, "R1 neg overflow");
  endtask

  task automatic t_sub();
    apply(16'h0005, 16'h0003, 0, 0, 4'd1, "R2 sub");
    apply(16'h0003, 16'h0005, 0, 0, 4'd1, "R2 borrow");
    apply(16'h8000, 16'h0001, 0, 0, 4'd1, "R2 overflow");
    apply(16'hABCD, 16'hABCD, 0, 0, 4'd1, "R2 zero");
  endtask

  task automatic t_neg();
    apply(16'h0000, 16'h1111, 0, 0, 4'd8, "R3 neg zero");
    apply(16'h0001, 16'h0, 0, 0, 4'd8, "R3 neg one");
    apply(16'h8000, 16'h0, 0, 0, 4'd8, "R3 neg min");
  endtask

  task automatic t_logic();
    for (int o = 2; o <= 4; o++) begin
      apply(16'hF0F0, 16'hFF00, 0, 0, 4'(o), "R4 logic");
      apply(16'h0000, 16'hFFFF, 0, 0, 4'(o), "R4 logic edge");
    end
    apply(16'h5A5A, 16'h0, 0, 0, 4'd9, "R5 not");
    apply(16'hFFFF, 16'h0, 0, 0, 4'd9, "R5 not zero");
  endtask

  task automatic t_shift();
    apply(16'h8001, 16'h0, 0, 0, 4'd5, "R6 shl");
    apply(16'h4000, 16'h0, 0, 0, 4'd5, "R6 shl no carry");
    apply(16'h8001, 16'h0, 0, 0, 4'd6, "R7 shr");
    apply(16'h8001, 16'h0, 0, 0, 4'd7, "R7 sar");
    apply(16'h4002, 16'h0, 0, 0, 4'd7, "R7 sar positive");
  endtask

  task automatic t_bits();
    for (int i = 0; i < 16; i++) begin
      for (int o = 10; o <= 13; o++) begin
        apply(16'hA5C3, 16'(i), 0, 0, 4'(o), "R8 R9 bitop");
        apply(16'h5A3C, 16'hFFF0 | 16'(i), 0, 0, 4'(o), "R8 R9 bitop inv");
        apply(16'h0000, 16'(i), 0, 0, 4'(o), "R9 bitop zero");
        apply(16'hFFFF, 16'(i), 0, 0, 4'(o), "R9 bitop ones");
      end
    end
  endtask

  task automatic t_const();
    for (int s = 0; s < 8; s++) begin
      apply(16'h1234, 16'h0F0F, 3'(s), 0, 4'd0, "R10 x const");
      apply(16'h1234, 16'h0F0F, 0, 3'(s), 4'd1, "R10 y const");
      apply(16'hFFFF, 16'h0000, 0, 3'(s), 4'd11, "R10 y const idx");
    end
    apply(16'h9999, 16'h9999, 3'd1, 3'd1, 4'd0, "R10 zero both");
  endtask

  task automatic t_rsv();
    apply(16'hFFFF, 16'h8000, 0, 0, 4'd14, "R12 rsv14");
    apply(16'h8000, 16'hFFFF, 0, 0, 4'd15, "R12 rsv15");
  endtask

  task automatic t_random();
    for (int k = 0; k < 3000; k++)
      apply(16'($urandom), 16'($urandom), 3'($urandom_range(0, 7)),
            3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)), "R1..random");
  endtask

  initial begin
    x = '0; y = '0; xs = '0; ys = '0; op = '0;
    void'($urandom(32'h1D5));
    t_idle();
    t_add();
    t_sub();
    t_neg();
    t_logic();
    t_shift();
    t_bits();
    t_const();
    t_rsv();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule